// File: doc/BRIEF.md
# Accumulator Processor with Index Register

A small multi-cycle processor built around a 16-bit accumulator. It shares one word-addressed memory port between instruction fetch and data access. Every instruction is one 16-bit word: a 4-bit opcode in bits 15:12 and a 12-bit address field S in bits 11:0. A 12-bit program counter steps through memory. A 12-bit index register can be loaded from memory, stepped up or down, and added to S to form the address of accumulator loads and stores.

Each instruction takes two clock cycles. The fetch cycle reads the word at the program counter into the instruction register and advances the counter. The execute cycle carries out the operation: either one access to the effective address, or a register-only action. A halt instruction stops the processor until the next synchronous reset.

Top module: `idx_acc_cpu`

## Requirements
- R1: A synchronous reset (active high) clears the program counter, accumulator, index register and halted flag. The first cycle after reset is a fetch from address 0.
- R2: Every instruction takes two cycles. The fetch cycle asserts the read strobe at the program counter and advances it by one. The execute cycle follows directly.
- R3: Opcode 0 loads the accumulator from mem[S] and opcode 1 stores it to mem[S]. Opcode 2 adds mem[S] and opcode 3 subtracts mem[S]. Both are modulo 2^16.
- R4: Opcode 4 jumps to S unconditionally. Opcode 5 jumps to S when accumulator bit 15 is 0. Opcode 6 jumps to S when the accumulator is non-zero. A jump that is not taken continues at the next word.
- R5: Opcode 7 halts. The halted output rises after its execute cycle and stays high, and no memory strobe is asserted, until reset.
- R6: Opcode 8 loads the index register with bits 11:0 of mem[S].
- R7: Opcode 9 loads the accumulator from, and opcode A stores it to, address (S + index) modulo 2^12.
- R8: Opcode B increments and opcode C decrements the index register, both modulo 2^12, with no memory access.
- R9: Opcodes D, E and F do nothing but take their two cycles.
- R10: At most one of the read and write strobes is active in any cycle. During a store, the write data equals the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Word address of the memory access |
| memWdata | output | 16 | Data written to memory |
| memRdata | input | 16 | Data read from memory, valid in the same cycle as the address |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench goes after wrap-around of the index register in both directions. A design that carried into a 13th bit, or sign-extended, would store at the wrong word and leave an expected location zero. It checks that loading the index keeps only the low 12 bits of a word whose top nibble is set, and that an indexed address past 0xFFF wraps back to a low word. Taken and not-taken cases of each conditional jump are placed so that a wrong decision writes a trap location. An exact cycle count to halt exposes a no-operation or register-only opcode that wrongly took an extra cycle or stalled. After the halt, the bench watches that no strobe moves and that a later write instruction never lands.

// File: rtl/idxcpu_pkg.sv
package idxcpu_pkg;

  typedef enum logic [3:0] {
    OP_LDA  = 4'h0,
    OP_STO  = 4'h1,
    OP_ADD  = 4'h2,
    OP_SUB  = 4'h3,
    OP_JMP  = 4'h4,
    OP_JGE  = 4'h5,
    OP_JNE  = 4'h6,
    OP_STP  = 4'h7,
    OP_LDX  = 4'h8,
    OP_LDAX = 4'h9,
    OP_STAX = 4'hA,
    OP_INX  = 4'hB,
    OP_DEX  = 4'hC
  } opcode_e;

  typedef enum logic [1:0] {ADDR_PC, ADDR_S, ADDR_SX} addrSel_e;
  typedef enum logic [1:0] {ACC_MEM, ACC_ADD, ACC_SUB} accSel_e;
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} cpuState_e;

  typedef struct packed {
    logic     irLoad;
    logic     pcInc;
    logic     pcLoad;
    logic     accLoad;
    accSel_e  accSel;
    logic     xLoad;
    logic     xInc;
    logic     xDec;
    addrSel_e addrSel;
    logic     memRd;
    logic     memWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/idxcpu_ctrl.sv
module idxcpu_ctrl
  import idxcpu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   opcode,
  input  logic         accNeg,
  input  logic         accZero,
  output ctrlStrobes_t ctl,
  output logic         halted
);

  cpuState_e state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_FETCH: begin
        ctl.irLoad  = 1'b1;
        ctl.pcInc   = 1'b1;
        ctl.addrSel = ADDR_PC;
        ctl.memRd   = 1'b1;
        stateNext   = ST_EXEC;
      end
      ST_EXEC: begin
        stateNext = (opcode == OP_STP) ? ST_HALT : ST_FETCH;
        case (opcode)
          OP_LDA:  begin ctl.addrSel = ADDR_S;  ctl.memRd = 1'b1; ctl.accLoad = 1'b1; ctl.accSel = ACC_MEM; end
          OP_STO:  begin ctl.addrSel = ADDR_S;  ctl.memWr = 1'b1; end
          OP_ADD:  begin ctl.addrSel = ADDR_S;  ctl.memRd = 1'b1; ctl.accLoad = 1'b1; ctl.accSel = ACC_ADD; end
          OP_SUB:  begin ctl.addrSel = ADDR_S;  ctl.memRd = 1'b1; ctl.accLoad = 1'b1; ctl.accSel = ACC_SUB; end
          OP_JMP:  ctl.pcLoad = 1'b1;
          OP_JGE:  ctl.pcLoad = !accNeg;
          OP_JNE:  ctl.pcLoad = !accZero;
          OP_LDX:  begin ctl.addrSel = ADDR_S;  ctl.memRd = 1'b1; ctl.xLoad = 1'b1; end
          OP_LDAX: begin ctl.addrSel = ADDR_SX; ctl.memRd = 1'b1; ctl.accLoad = 1'b1; ctl.accSel = ACC_MEM; end
          OP_STAX: begin ctl.addrSel = ADDR_SX; ctl.memWr = 1'b1; end
          OP_INX:  ctl.xInc = 1'b1;
          OP_DEX:  ctl.xDec = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNext;
  end

  assign halted = (state == ST_HALT);

  // R5: halt is sticky until reset
  p_halt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R5: no memory traffic while halted
  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!ctl.memRd && !ctl.memWr));

  // R2: a fetch is never followed by another fetch
  p_exec_follows_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.irLoad |=> !ctl.irLoad);

endmodule

// File: rtl/idxcpu_dpath.sv
module idxcpu_dpath
  import idxcpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobes_t               ctl,
  input  logic [DATA_W-1:0]          memRdata,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          memWdata,
  output logic [DATA_W-ADDR_W-1:0]   opcode,
  output logic                       accNeg,
  output logic                       accZero
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pc, x, sField;
  logic [DATA_W-1:0] acc, ir;

  assign sField = ir[ADDR_W-1:0];
  assign opcode = ir[DATA_W-1:ADDR_W];

  always_comb begin
    case (ctl.addrSel)
      ADDR_S:  memAddr = sField;
      ADDR_SX: memAddr = sField + x;
      default: memAddr = pc;
    endcase
  end

  assign memWdata = acc;
  assign accNeg   = acc[DATA_W-1];
  assign accZero  = (acc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      acc <= '0;
      x   <= '0;
      ir  <= '0;
    end else begin
      if (ctl.irLoad) ir <= memRdata;
      if (ctl.pcInc)       pc <= pc + ADDR_ONE;
      else if (ctl.pcLoad) pc <= sField;
      if (ctl.accLoad) begin
        case (ctl.accSel)
          ACC_ADD: acc <= acc + memRdata;
          ACC_SUB: acc <= acc - memRdata;
          default: acc <= memRdata;
        endcase
      end
      if (ctl.xLoad)     x <= memRdata[ADDR_W-1:0];
      else if (ctl.xInc) x <= x + ADDR_ONE;
      else if (ctl.xDec) x <= x - ADDR_ONE;
    end
  end

  // R1: reset leaves all architectural registers at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (pc == '0 && acc == '0 && x == '0));

  // R2: fetch advances the program counter by one
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.irLoad |=> pc == $past(pc) + ADDR_ONE);

  // R6: index load keeps the low address bits of the read word
  p_xload_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.xLoad |=> x == $past(memRdata[ADDR_W-1:0]));

  // R8: increment and decrement wrap in the address width
  p_xinc_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.xInc |=> x == $past(x) + ADDR_ONE);
  p_xdec_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.xDec |=> x == $past(x) - ADDR_ONE);

endmodule

// File: rtl/idx_acc_cpu.sv
module idx_acc_cpu
  import idxcpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRd,
  output logic              memWr,
  output logic              halted
);

  localparam int OP_W = DATA_W - ADDR_W;

  ctrlStrobes_t      ctl;
  logic [OP_W-1:0]   opcode;
  logic              accNeg, accZero;

  idxcpu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .accNeg  (accNeg),
    .accZero (accZero),
    .ctl     (ctl),
    .halted  (halted)
  );

  idxcpu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode),
    .accNeg   (accNeg),
    .accZero  (accZero)
  );

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;

  // R10: read and write strobes are exclusive
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));

endmodule

// File: tb/tb_idx_acc_cpu.sv
`timescale 1ns/1ps
module tb_idx_acc_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic        memRd, memWr, halted;

  int checks = 0;
  int errors = 0;
  int strobeClash = 0;

  always #10 clk = ~clk;

  idx_acc_cpu dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRd(memRd), .memWr(memWr), .halted(halted)
  );

  // bench memory: 256 words, single writer process
  logic [15:0] mem [256];
  logic        tbWe = 1'b0;
  logic [7:0]  tbAddr = '0;
  logic [15:0] tbData = '0;

  assign memRdata = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (tbWe)       mem[tbAddr] <= tbData;
    else if (memWr) mem[memAddr[7:0]] <= memWdata;
  end

  always @(negedge clk) begin
    if (!rst && memRd && memWr) strobeClash++;
  end

  // program and data image: {address, word}
  localparam int NIMG = 36;
  localparam logic [23:0] IMG [NIMG] = '{
    {8'h00,16'h8040}, {8'h01,16'h9050}, {8'h02,16'hA060}, {8'h03,16'hB000},
    {8'h04,16'hA060}, {8'h05,16'hC000}, {8'h06,16'hC000}, {8'h07,16'h9050},
    {8'h08,16'h2041}, {8'h09,16'h3042}, {8'h0A,16'h1070}, {8'h0B,16'h5020},
    {8'h0C,16'h2043}, {8'h0D,16'h6020}, {8'h0E,16'h5010}, {8'h0F,16'h1071},
    {8'h10,16'h4016}, {8'h11,16'h1071}, {8'h16,16'hD000}, {8'h17,16'hF000},
    {8'h18,16'h8044}, {8'h19,16'hC000}, {8'h1A,16'h9052}, {8'h1B,16'h1072},
    {8'h1C,16'h8045}, {8'h1D,16'hB000}, {8'h1E,16'hA073}, {8'h1F,16'h6022},
    {8'h20,16'h1074}, {8'h21,16'h1075}, {8'h22,16'h7000}, {8'h23,16'h1076},
    {8'h40,16'h0002}, {8'h41,16'h0003}, {8'h42,16'h000A}, {8'h43,16'h0002}
  };
  localparam int NDATA = 4;
  localparam logic [23:0] DATA2 [NDATA] = '{
    {8'h44,16'h0000}, {8'h45,16'hAFFF}, {8'h51,16'h0005}, {8'h52,16'h0007}
  };

  // expected memory after the run: {requirement number, address, word}
  localparam int NEXP = 11;
  localparam logic [31:0] EXPV [NEXP] = '{
    {8'd7,  8'h62, 16'h0007},  // R7 indexed load then store with X=2
    {8'd8,  8'h63, 16'h0007},  // R8 increment then indexed store
    {8'd3,  8'h70, 16'hFFFE},  // R3 5+3-10 wraps
    {8'd4,  8'h71, 16'h0000},  // R4 taken JGE and JMP skip traps
    {8'd8,  8'h72, 16'h0005},  // R8 decrement 0 -> FFF, R7 address wrap
    {8'd6,  8'h73, 16'h0005},  // R6 load keeps 12 bits, R8 FFF+1 -> 0
    {8'd4,  8'h74, 16'h0000},  // R4 taken JNE skips
    {8'd4,  8'h75, 16'h0000},  // R4
    {8'd5,  8'h76, 16'h0000},  // R5 no store after halt
    {8'd10, 8'h52, 16'h0007},  // R10 source untouched by stores
    {8'd10, 8'h51, 16'h0005}   // R10
  };

  localparam int EXP_CYCLES = 54;  // 27 instructions x 2 cycles (R2, R9)

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic runToHalt(output int cycles);
    cycles = 0;
    while (!halted && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    rst = 1'b1;
    for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
    for (int i = 0; i < NIMG; i++) poke(IMG[i][23:16], IMG[i][15:0]);
    for (int i = 0; i < NDATA; i++) poke(DATA2[i][23:16], DATA2[i][15:0]);

    @(negedge clk);
    check(!halted && !memWr, "R1 reset state", {halted, memWr}, 0);
    rst = 1'b0;
    #1;
    check(memRd && memAddr == 12'h000, "R1 first fetch at 0", memAddr, 0);
    @(negedge clk);
    check(memRd && !memWr && memAddr == 12'h040, "R2 execute of LDX reads S", memAddr, 12'h040);
    runToHalt(cyc);
    cyc++;
    check(cyc == EXP_CYCLES, "R9 cycles to halt", cyc, EXP_CYCLES);
    check(halted, "R5 halted high", halted, 1);

    for (int i = 0; i < NEXP; i++) begin
      if (mem[EXPV[i][23:16]] !== EXPV[i][15:0]) begin
        checks++; errors++;
        $display("FAIL R%0d mem[0x%0h] actual=0x%0h expected=0x%0h",
                 EXPV[i][31:24], EXPV[i][23:16], mem[EXPV[i][23:16]], EXPV[i][15:0]);
      end else checks++;
    end

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(halted && !memRd && !memWr, "R5 quiet while halted", {halted, memRd, memWr}, 3'b100);
    end
    check(mem[8'h76] == 16'h0000, "R5 no store after halt", mem[8'h76], 0);
    check(strobeClash == 0, "R10 strobe exclusivity", strobeClash, 0);

    // reset after halt clears the flag and restarts at 0
    rst = 1'b1;
    @(negedge clk);
    check(!halted, "R1 reset clears halted", halted, 0);
    rst = 1'b0;
    #1;
    check(memRd && memAddr == 12'h000, "R1 restart fetch at 0", memAddr, 0);

    // reset in the middle of a run
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(memRd && memAddr == 12'h000, "R1 mid-run reset refetches 0", memAddr, 0);
    runToHalt(cyc);
    check(cyc == EXP_CYCLES, "R2 rerun cycle count", cyc, EXP_CYCLES);
    check(mem[8'h73] == 16'h0005 && mem[8'h70] == 16'hFFFE, "R7 rerun results", mem[8'h73], 16'h0005);
    check(strobeClash == 0, "R10 strobe exclusivity rerun", strobeClash, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule